// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the transmit and receive frame sync signals for a synchronous serial audio port. A period counter advances once per bit clock. The bit clock arrives as a one-cycle tick in the system clock domain, taken from either an internal or an external source. Software sets the frame length and the active pulse length through three write-only registers. Both lengths are in bit clocks and are written as the count minus one.

Two enable bits bring the block out of reset in stages. The sample generator enable comes first. The frame sync enable then starts the pulses. A mode bit picks between two ways of running. In one, the generator repeats frames without a break. In the other, each transfer event produces exactly one frame. Each direction has its own polarity bit. Each direction also has its own source bit, which selects the internal pulse or passes an external sync pin straight through.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset the generator register holds period 31, width 15 and continuous mode. Both enables are clear. All pin-control bits are 0, so each sync output follows its external sync pin.
- R2: The period field sits in bits 27:16 of the generator register (select 0) and holds the frame length in bit clocks minus one. The counter returns to 0 on the tick where it has reached or passed that value.
- R3: The width field sits in bits 15:8 of the generator register and holds the active length minus one. The internal sync is active for the first width+1 ticks of each frame.
- R4: When the width value is greater than or equal to the period value, the internal sync stays active for the whole time the generator runs.
- R5: The control register (select 1) has the generator enable at bit 22 and the frame sync enable at bit 23. The sync runs only when both are set. The first selected tick after that starts a frame at count 0, and that tick is active.
- R6: If either enable is cleared, the next selected tick drives the sync inactive and resets the counter. Enabling again starts a new frame from count 0.
- R7: Generator register bit 28 set means frames repeat without a gap. With bit 28 clear, the block stays inactive until a pulse on xfer_evt. The next tick after that pulse starts exactly one frame, and the block then returns to inactive.
- R8: Pin-control register (select 2) bit 0 sets transmit polarity and bit 1 sets receive polarity. A value of 0 gives active high and 1 gives active low, where the inactive level is high.
- R9: Pin-control bit 5 (transmit) and bit 6 (receive) set to 1 select the internal sync. Set to 0, the output equals the external sync pin in the same cycle, and polarity does not apply.
- R10: Pin-control bit 4 set to 1 selects int_bclk_tick and set to 0 selects ext_bclk_tick. A tick on the unselected input has no effect.
- R11: The counter and the sync hold their values in every cycle with no selected tick.
- R12: A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 generator, 1 control, 2 pin control, 3 none |
| cfg_wdata | input | 32 | Register write data |
| int_bclk_tick | input | 1 | Internal bit clock tick, one cycle wide |
| ext_bclk_tick | input | 1 | External bit clock tick, already synchronised |
| xfer_evt | input | 1 | Transfer event that requests one frame in triggered mode |
| ext_tx_fs | input | 1 | External transmit sync pin |
| ext_rx_fs | input | 1 | External receive sync pin |
| tx_fs | output | 1 | Transmit frame sync |
| rx_fs | output | 1 | Receive frame sync |

## Verification
A register write takes effect at the rising edge where cfg_we is sampled. The internal sync moves at the rising edge that samples a selected tick, with one register stage and no further delay. An external sync pin reaches its output combinationally in the same cycle. The bench changes inputs on falling edges and holds each tick high for exactly one rising edge. It reads the outputs at the next falling edge, which is the first point where the result is due. For pass-through checks it reads them 1 ns after changing the pin. Expected levels come from the frame position, which the bench counts in ticks since the frame started.

// File: rtl/fsgen_pkg.sv
package fsgen_pkg;

   localparam int REG_W        = 32;
   // generator register fields
   localparam int PER_LSB      = 16;
   localparam int PER_BITS     = 12;
   localparam int WID_LSB      = 8;
   localparam int WID_BITS     = 8;
   localparam int CONT_BIT     = 28;
   // control register fields
   localparam int GEN_EN_BIT   = 22;
   localparam int FS_EN_BIT    = 23;
   // pin-control register fields
   localparam int TXPOL_BIT    = 0;
   localparam int RXPOL_BIT    = 1;
   localparam int BCLK_INT_BIT = 4;
   localparam int TXFS_INT_BIT = 5;
   localparam int RXFS_INT_BIT = 6;

   typedef enum logic [1:0] {
      SEL_GEN  = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_PIN  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [PER_BITS-1:0] period;
      logic [WID_BITS-1:0] width;
      logic                cont;
   } gen_cfg_t;

   typedef struct packed {
      logic gen_en;
      logic fs_en;
   } run_ctl_t;

   typedef struct packed {
      logic tx_pol;
      logic rx_pol;
      logic bclk_int;
      logic tx_int;
      logic rx_int;
   } pin_cfg_t;

endpackage

// File: rtl/fsgen_regs.sv
module fsgen_regs
   import fsgen_pkg::*;
#(
   parameter int DEF_PERIOD = 31,
   parameter int DEF_WIDTH  = 15,
   parameter bit DEF_CONT   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       sel,
   input  logic [REG_W-1:0] wdata,
   output gen_cfg_t         gen,
   output run_ctl_t         ctl,
   output pin_cfg_t         pin
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen.period <= PER_BITS'(DEF_PERIOD);
         gen.width  <= WID_BITS'(DEF_WIDTH);
         gen.cont   <= DEF_CONT;
         ctl        <= '0;
         pin        <= '0;
      end else if (we) begin
         case (reg_sel_e'(sel))
            SEL_GEN: begin
               gen.period <= wdata[PER_LSB +: PER_BITS];
               gen.width  <= wdata[WID_LSB +: WID_BITS];
               gen.cont   <= wdata[CONT_BIT];
            end
            SEL_CTRL: begin
               ctl.gen_en <= wdata[GEN_EN_BIT];
               ctl.fs_en  <= wdata[FS_EN_BIT];
            end
            SEL_PIN: begin
               pin.tx_pol   <= wdata[TXPOL_BIT];
               pin.rx_pol   <= wdata[RXPOL_BIT];
               pin.bclk_int <= wdata[BCLK_INT_BIT];
               pin.tx_int   <= wdata[TXFS_INT_BIT];
               pin.rx_int   <= wdata[RXFS_INT_BIT];
            end
            default: ;
         endcase
      end
   end

   // R5
   ctrl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_CTRL && !wdata[GEN_EN_BIT]) |=> !ctl.gen_en);

   // R12
   no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_NONE) |=> ($stable(gen) && $stable(ctl) && $stable(pin)));

endmodule

// File: rtl/fsgen_engine.sv
module fsgen_engine
   import fsgen_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     xfer_evt,
   input  gen_cfg_t cfg,
   input  run_ctl_t ctl,
   output logic     gen_active
);

   localparam int CW = PER_BITS;

   logic [CW-1:0] cnt;
   logic          run;
   logic          pend;
   logic          en;
   logic          wrap;
   logic [CW-1:0] width_ext;

   assign en        = ctl.gen_en & ctl.fs_en;
   assign width_ext = CW'(cfg.width);
   assign wrap      = (cnt >= cfg.period);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         run  <= 1'b0;
         pend <= 1'b0;
      end else if (tick) begin
         if (!en) begin
            cnt  <= '0;
            run  <= 1'b0;
            pend <= 1'b0;
         end else if (!run) begin
            if (cfg.cont || pend) begin
               run <= 1'b1;
               cnt <= '0;
            end
            pend <= xfer_evt;
         end else if (wrap) begin
            cnt  <= '0;
            run  <= cfg.cont | pend;
            pend <= xfer_evt;
         end else begin
            cnt <= cnt + 1'b1;
            if (xfer_evt) pend <= 1'b1;
         end
      end else if (xfer_evt && en) begin
         pend <= 1'b1;
      end
   end

   assign gen_active = run && (cnt <= width_ext);

   // R6
   dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !en) |=> !gen_active);

   // R2
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && run && wrap) |=> (cnt == '0));

   // R7
   cont_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && cfg.cont) |=> run);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !$isunknown(cnt)) |=> $stable(cnt));

endmodule

// File: rtl/fsgen_outsel.sv
module fsgen_outsel #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gen_active,
   input  logic pol,
   input  logic int_sel,
   input  logic ext_fs,
   output logic fs
);

   logic pick;

   assign pick = int_sel ? (gen_active ^ pol) : ext_fs;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) fs <= 1'b0;
            else        fs <= pick;
         end
      end else begin : g_comb
         assign fs = pick;
      end
   endgenerate

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
   import fsgen_pkg::*;
#(
   parameter int DEF_PERIOD = 31,
   parameter int DEF_WIDTH  = 15,
   parameter bit DEF_CONT   = 1'b1,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic             int_bclk_tick,
   input  logic             ext_bclk_tick,
   input  logic             xfer_evt,
   input  logic             ext_tx_fs,
   input  logic             ext_rx_fs,
   output logic             tx_fs,
   output logic             rx_fs
);

   localparam int NDIR = 2;

   generate
      if (DEF_PERIOD < 0 || DEF_PERIOD >= (1 << PER_BITS)) begin : g_bad_period
         $error("DEF_PERIOD does not fit the period field");
      end
      if (DEF_WIDTH < 0 || DEF_WIDTH >= (1 << WID_BITS)) begin : g_bad_width
         $error("DEF_WIDTH does not fit the width field");
      end
      if (WID_BITS > PER_BITS) begin : g_bad_fields
         $error("width field wider than period field");
      end
   endgenerate

   gen_cfg_t gen;
   run_ctl_t ctl;
   pin_cfg_t pin;
   logic     tick;
   logic     gen_active;

   logic [NDIR-1:0] pol_v;
   logic [NDIR-1:0] int_v;
   logic [NDIR-1:0] ext_v;
   logic [NDIR-1:0] fs_v;

   fsgen_regs #(
      .DEF_PERIOD (DEF_PERIOD),
      .DEF_WIDTH  (DEF_WIDTH),
      .DEF_CONT   (DEF_CONT)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .sel   (cfg_sel),
      .wdata (cfg_wdata),
      .gen   (gen),
      .ctl   (ctl),
      .pin   (pin)
   );

   assign tick = pin.bclk_int ? int_bclk_tick : ext_bclk_tick;

   fsgen_engine u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .xfer_evt   (xfer_evt),
      .cfg        (gen),
      .ctl        (ctl),
      .gen_active (gen_active)
   );

   assign pol_v = {pin.rx_pol, pin.tx_pol};
   assign int_v = {pin.rx_int, pin.tx_int};
   assign ext_v = {ext_rx_fs, ext_tx_fs};

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
         fsgen_outsel #(.OUT_REG(OUT_REG)) u_out (
            .clk        (clk),
            .rst_n      (rst_n),
            .gen_active (gen_active),
            .pol        (pol_v[d]),
            .int_sel    (int_v[d]),
            .ext_fs     (ext_v[d]),
            .fs         (fs_v[d])
         );
      end
   endgenerate

   assign tx_fs = fs_v[0];
   assign rx_fs = fs_v[1];

   // R4
   full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctl.gen_en && ctl.fs_en && gen.cont && gen.width >= gen.period)
      |=> (!pin.tx_int || OUT_REG || tx_fs == !pin.tx_pol));

endmodule

// File: tb/sim_frame_sync_gen.sv
module sim_frame_sync_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        int_t = 1'b0;
   logic        ext_t = 1'b0;
   logic        xfer_evt = 1'b0;
   logic        ext_tx = 1'b0;
   logic        ext_rx = 1'b0;
   logic        tx_fs;
   logic        rx_fs;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   frame_sync_gen u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_sel       (cfg_sel),
      .cfg_wdata     (cfg_wdata),
      .int_bclk_tick (int_t),
      .ext_bclk_tick (ext_t),
      .xfer_evt      (xfer_evt),
      .ext_tx_fs     (ext_tx),
      .ext_rx_fs     (ext_rx),
      .tx_fs         (tx_fs),
      .rx_fs         (rx_fs)
   );

   function automatic logic [31:0] gcfg(input int p, input int w, input bit c);
      return {3'b000, c, 12'(p), 8'(w), 8'h00};
   endfunction

   function automatic logic [31:0] ctrlv(input bit g, input bit f);
      return (32'(g) << 22) | (32'(f) << 23);
   endfunction

   function automatic logic [31:0] pins(input bit txp, input bit rxp,
                                        input bit bint, input bit txi, input bit rxi);
      return 32'(txp) | (32'(rxp) << 1) | (32'(bint) << 4) | (32'(txi) << 5) | (32'(rxi) << 6);
   endfunction

   function automatic logic exp_act(input int pos, input int w);
      return (pos <= w);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic tick_int();
      @(negedge clk) int_t = 1'b1;
      @(negedge clk) int_t = 1'b0;
   endtask

   task automatic tick_ext();
      @(negedge clk) ext_t = 1'b1;
      @(negedge clk) ext_t = 1'b0;
   endtask

   task automatic start_gen(input int p, input int w, input bit c);
      wr(2'd1, 32'h0);
      tick_int();
      wr(2'd0, gcfg(p, w, c));
      wr(2'd1, ctrlv(1'b1, 1'b1));
   endtask

   task automatic run_check(input string req, input int p, input int w, input int n,
                            input bit txp, input bit rxp);
      for (int m = 0; m < n; m++) begin
         logic e;
         tick_int();
         e = exp_act(m % (p + 1), w);
         chk(req, tx_fs, e ^ txp);
         chk(req, rx_fs, e ^ rxp);
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: outputs follow external pins after reset
      ext_tx = 1'b1; ext_rx = 1'b0; #1;
      chk("R1", tx_fs, 1'b1);
      chk("R1", rx_fs, 1'b0);
      ext_tx = 1'b0; ext_rx = 1'b1; #1;
      chk("R1", tx_fs, 1'b0);
      chk("R1", rx_fs, 1'b1);

      // R1: enables clear after reset -> internal sync inactive
      wr(2'd2, pins(0, 0, 1, 1, 1));
      repeat (3) tick_int();
      chk("R1", tx_fs, 1'b0);

      // R1, R3: default period 31 / width 15 continuous
      wr(2'd1, ctrlv(1, 1));
      run_check("R1", 31, 15, 64, 0, 0);

      // R11: no change between ticks
      begin
         logic held;
         held = tx_fs;
         repeat (4) @(negedge clk);
         chk("R11", tx_fs, held);
      end

      // R2, R3: directed small frame
      start_gen(5, 2, 1);
      run_check("R2", 5, 2, 18, 0, 0);

      // R4: width >= period
      start_gen(4, 4, 1);
      run_check("R4", 4, 4, 10, 0, 0);
      start_gen(3, 9, 1);
      run_check("R4", 3, 9, 8, 0, 0);

      // R5: staged enables
      wr(2'd1, 32'h0);
      tick_int();
      wr(2'd0, gcfg(5, 2, 1));
      wr(2'd1, ctrlv(1, 0));
      repeat (3) begin tick_int(); chk("R5", tx_fs, 1'b0); end
      wr(2'd1, ctrlv(0, 1));
      tick_int(); chk("R5", tx_fs, 1'b0);
      wr(2'd1, ctrlv(1, 1));
      run_check("R5", 5, 2, 8, 0, 0);

      // R6: clear mid-frame, restart from 0
      start_gen(7, 3, 1);
      run_check("R6", 7, 3, 2, 0, 0);
      wr(2'd1, ctrlv(1, 0));
      tick_int(); chk("R6", tx_fs, 1'b0);
      tick_int(); chk("R6", tx_fs, 1'b0);
      wr(2'd1, ctrlv(1, 1));
      run_check("R6", 7, 3, 10, 0, 0);

      // R7: triggered mode, one frame per event
      start_gen(3, 0, 0);
      repeat (3) begin tick_int(); chk("R7", tx_fs, 1'b0); end
      @(negedge clk) xfer_evt = 1'b1;
      @(negedge clk) xfer_evt = 1'b0;
      run_check("R7", 3, 0, 4, 0, 0);
      repeat (4) begin tick_int(); chk("R7", tx_fs, 1'b0); end

      // R8: polarity per direction
      wr(2'd2, pins(1, 0, 1, 1, 1));
      start_gen(5, 1, 1);
      run_check("R8", 5, 1, 12, 1, 0);
      wr(2'd2, pins(0, 1, 1, 1, 1));
      start_gen(5, 1, 1);
      run_check("R8", 5, 1, 6, 0, 1);

      // R9: receive from external pin while transmit internal, pol ignored
      wr(2'd2, pins(0, 1, 1, 1, 0));
      ext_rx = 1'b0; #1; chk("R9", rx_fs, 1'b0);
      ext_rx = 1'b1; #1; chk("R9", rx_fs, 1'b1);
      ext_rx = 1'b0; #1; chk("R9", rx_fs, 1'b0);

      // R10: unselected tick ignored, then switch source
      wr(2'd2, pins(0, 0, 1, 1, 1));
      start_gen(5, 2, 1);
      run_check("R10", 5, 2, 3, 0, 0);
      tick_ext(); chk("R10", tx_fs, 1'b1);
      wr(2'd2, pins(0, 0, 0, 1, 1));
      tick_ext(); chk("R10", tx_fs, 1'b0);
      tick_int(); chk("R10", tx_fs, 1'b0);
      tick_ext(); chk("R10", tx_fs, 1'b0);
      tick_ext(); chk("R10", tx_fs, 1'b0);
      tick_ext(); chk("R10", tx_fs, 1'b1);
      wr(2'd2, pins(0, 0, 1, 1, 1));

      // R12: select 3 writes ignored
      start_gen(5, 2, 1);
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd3, 32'h0000_0000);
      run_check("R12", 5, 2, 12, 0, 0);

      // R2, R3: random configurations
      for (int k = 0; k < 8; k++) begin
         int p;
         int w;
         bit txp;
         p   = 2 + int'($urandom % 30);
         w   = int'($urandom % (p + 4));
         txp = 1'($urandom);
         wr(2'd2, pins(txp, 0, 1, 1, 1));
         start_gen(p, w, 1);
         run_check("R3", p, w, 2 * (p + 1) + 3, txp, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule